// File: doc/BRIEF.md
# Split-Chain Ling Carry-Lookahead Adder

This block adds two unsigned operands and an input carry, and returns the sum together with a separate carry-out. It does not ripple a carry through every bit, and it does not build one lookahead tree. Instead it runs two interleaved pseudo-carry chains. One chain serves the even bit positions and the other serves the odd positions. Each link of a chain reaches back two positions, to the previous pseudo-carry of the same parity. The two chains share no logic, so both settle in about half the number of steps a single ripple would take.

Each bit first forms three local terms: a generate (AND), an exclusive propagate (XOR) and an inclusive propagate (OR). Each chain link combines a grouped generate and a grouped propagate with the pseudo-carry two places down. A true carry is recovered by gating a pseudo-carry with the inclusive propagate of its own bit. Each sum bit is the exclusive propagate XORed with the true carry from the bit below. The datapath has no arithmetic operator.

A parameter selects one of two output forms. With the parameter set, the sum and carry-out are captured in a register that the reset clears. With it cleared, the outputs come straight from the combinational core and the clock and reset inputs are unused.

Top module: `ling_adder`

## Requirements
- R1: For every pair of operands and both carry-in values, {cout, sum} equals a + b + cin, taken as an unsigned WIDTH+1-bit number.
- R2: The carry out of each even bit position 2k equals the carry of the unsigned sum a[2k:0] + b[2k:0] + cin. This holds even when carries reach only the even positions (operands 0x55 + 0x55).
- R3: The carry out of each odd bit position 2k+1 equals the carry of a[2k+1:0] + b[2k+1:0] + cin. This holds even when carries reach only the odd positions (operands 0xAA + 0xAA).
- R4: cout is the carry out of the top bit. It is 1 for a full-length propagate run that is started by the lowest bit (0xFF + 0x01). It is 0 whenever neither operand has its top bit set.
- R5: Sum bit 0 is a[0] XOR b[0] XOR cin, so cin alone sets sum bit 0 when both operands are zero.
- R6: With OUT_REG = 1, sum and cout change only at a rising clock edge. They show the inputs sampled at that edge, so they trail the inputs by exactly one cycle.
- R7: With OUT_REG = 1, while rst_n is low, sum and cout are 0 whatever the operands are.
- R8: With OUT_REG = 0, sum and cout follow the inputs with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low clear of the output register |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Input carry |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The bench builds two copies at the default WIDTH of 8, one with OUT_REG = 1 and one with OUT_REG = 0, and drives both from the same inputs. Eight bits make every operand pair with both carry-in values affordable, so every pseudo-carry path in both chains is reached, including the full-length propagate runs. The registered copy also covers the one-cycle latency and the reset clear, and the combinational copy covers same-cycle response.

// File: rtl/ling_pkg.sv
package ling_pkg;

   localparam int unsigned LING_MIN_WIDTH = 2;

   // grouped generate over a pair of neighbouring bits
   function automatic logic pair_gen(input logic g_hi, input logic g_lo);
      return g_hi | g_lo;
   endfunction

   // grouped propagate: both XOR propagates of the pair and the OR propagate two below
   function automatic logic pair_prop(input logic p_hi, input logic p_lo, input logic t_lo2);
      return p_hi & p_lo & t_lo2;
   endfunction

   // one link of a two-step pseudo-carry chain
   function automatic logic chain_step(input logic grp_g, input logic grp_p, input logic h_prev);
      return grp_g | (grp_p & h_prev);
   endfunction

endpackage

// File: rtl/ling_bitterms.sv
module ling_bitterms #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] gen,
   output logic [WIDTH-1:0] xprop,
   output logic [WIDTH-1:0] oprop
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign gen[i]   = a[i] & b[i];
      assign xprop[i] = a[i] ^ b[i];
      assign oprop[i] = a[i] | b[i];
   end
endmodule

// File: rtl/ling_chain.sv
module ling_chain #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned PARITY = 0,
   localparam int unsigned LINKS = WIDTH / 2
) (
   input  logic [WIDTH-1:0] gen,
   input  logic [WIDTH-1:0] xprop,
   input  logic [WIDTH-1:0] oprop,
   input  logic             cin,
   output logic [LINKS-1:0] hchain
);
   import ling_pkg::*;

   if (PARITY > 1) begin : g_bad_parity
      $error("ling_chain: PARITY must be 0 or 1");
   end

   logic unused_terms;
   assign unused_terms = ^{gen, xprop, oprop};

   for (genvar k = 0; k < LINKS; k++) begin : g_link
      localparam int unsigned POS = 2 * k + PARITY;
      if (k == 0 && PARITY == 0) begin : g_seed_even
         assign hchain[k] = gen[0] | cin;
      end else if (k == 0) begin : g_seed_odd
         assign hchain[k] = chain_step(pair_gen(gen[1], gen[0]), xprop[1] & xprop[0], cin);
      end else begin : g_step
         assign hchain[k] = chain_step(pair_gen(gen[POS], gen[POS-1]),
                                       pair_prop(xprop[POS], xprop[POS-1], oprop[POS-2]),
                                       hchain[k-1]);
      end
   end
endmodule

// File: rtl/ling_recover.sv
module ling_recover #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] xprop,
   input  logic [WIDTH-1:0] oprop,
   input  logic [WIDTH-1:0] hpseudo,
   input  logic             cin,
   output logic [WIDTH-1:0] carry,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign carry[i] = oprop[i] & hpseudo[i];
      if (i == 0) begin : g_lsb
         assign sum[i] = xprop[i] ^ cin;
      end else begin : g_upper
         assign sum[i] = xprop[i] ^ carry[i-1];
      end
   end
   assign cout = carry[WIDTH-1];
endmodule

// File: rtl/ling_adder.sv
module ling_adder #(
   parameter int unsigned WIDTH   = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);
   import ling_pkg::*;

   localparam int unsigned HALF = WIDTH / 2;

   if (WIDTH < LING_MIN_WIDTH || (WIDTH % 2) != 0) begin : g_bad_width
      $error("ling_adder: WIDTH must be even and at least 2");
   end

   logic [WIDTH-1:0] gen_w, xp_w, op_w;
   logic [HALF-1:0]  h_even, h_odd;
   logic [WIDTH-1:0] hp_w, cy_w, sum_c;
   logic             cout_c;

   ling_bitterms #(.WIDTH(WIDTH)) terms_i (
      .a(a), .b(b), .gen(gen_w), .xprop(xp_w), .oprop(op_w));

   ling_chain #(.WIDTH(WIDTH), .PARITY(0)) even_i (
      .gen(gen_w), .xprop(xp_w), .oprop(op_w), .cin(cin), .hchain(h_even));

   ling_chain #(.WIDTH(WIDTH), .PARITY(1)) odd_i (
      .gen(gen_w), .xprop(xp_w), .oprop(op_w), .cin(cin), .hchain(h_odd));

   for (genvar k = 0; k < HALF; k++) begin : g_merge
      assign hp_w[2*k]   = h_even[k];
      assign hp_w[2*k+1] = h_odd[k];
   end

   ling_recover #(.WIDTH(WIDTH)) rec_i (
      .xprop(xp_w), .oprop(op_w), .hpseudo(hp_w), .cin(cin),
      .carry(cy_w), .sum(sum_c), .cout(cout_c));

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum  <= '0;
            cout <= 1'b0;
         end else begin
            sum  <= sum_c;
            cout <= cout_c;
         end
      end
   end else begin : g_comb
      logic unused_clkrst;
      assign unused_clkrst = clk ^ rst_n;
      assign sum  = sum_c;
      assign cout = cout_c;
   end
endmodule

// File: rtl/ling_adder_chk.sv
module ling_adder_chk #(
   parameter int unsigned WIDTH   = 8,
   parameter bit          OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [WIDTH-1:0] a,
   input logic [WIDTH-1:0] b,
   input logic             cin,
   input logic [WIDTH-1:0] sum,
   input logic             cout,
   input logic [WIDTH-1:0] cy
);
   function automatic logic ref_carry(input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
                                      input logic ci, input int unsigned pos);
      logic [WIDTH:0] mask;
      logic [WIDTH:0] tot;
      mask = ({{WIDTH{1'b0}}, 1'b1} << (pos + 1)) - 1'b1;
      tot  = ({1'b0, x} & mask) + ({1'b0, y} & mask) + {{WIDTH{1'b0}}, ci};
      return tot[pos+1];
   endfunction

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_cy
      if ((i % 2) == 0) begin : g_even
         AST_CARRY_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
            cy[i] == ref_carry(a, b, cin, i)); // R2
      end else begin : g_odd
         AST_CARRY_ODD: assert property (@(posedge clk) disable iff (!rst_n)
            cy[i] == ref_carry(a, b, cin, i)); // R3
      end
   end

   AST_TOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!a[WIDTH-1] && !b[WIDTH-1]) |-> !cy[WIDTH-1]); // R4

   if (OUT_REG) begin : g_reg_chk
      AST_SUM_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> ({cout, sum} == ({1'b0, $past(a)} + {1'b0, $past(b)} + {{WIDTH{1'b0}}, $past(cin)}))); // R6
   end else begin : g_comb_chk
      AST_SUM_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
         {cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})); // R8
   end
endmodule

bind ling_adder ling_adder_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) chk_i (
   .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin),
   .sum(sum), .cout(cout), .cy(cy_w));

// File: tb/ling_adder_tb_top.sv
module ling_adder_tb_top;
   localparam int unsigned W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] a = '0, b = '0;
   logic         cin = 1'b0;
   logic [W-1:0] sum_r, sum_c;
   logic         cout_r, cout_c;
   int           n_chk = 0, n_fail = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   ling_adder #(.WIDTH(W), .OUT_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum_r), .cout(cout_r));

   ling_adder #(.WIDTH(W), .OUT_REG(1'b0)) comb_i (
      .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum_c), .cout(cout_c));

   function automatic logic [W:0] expect_add(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci);
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
   endfunction

   task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h", req, a, b, cin, got, exp);
      end
   endtask

   // drive at a falling edge, check the comb copy at once, the registered copy one cycle later
   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci, input string req);
      logic [W:0] exp;
      logic [W:0] prev;
      prev = {cout_r, sum_r};
      a = x; b = y; cin = ci;
      exp = expect_add(x, y, ci);
      #1;
      check({req, "/R8"}, {cout_c, sum_c}, exp);
      check("R6 hold", {cout_r, sum_r}, prev);
      @(negedge clk);
      check(req, {cout_r, sum_r}, exp);
   endtask

   initial begin
      process_seed();
      @(negedge clk);
      a = 8'hA7; b = 8'h6C; cin = 1'b1;
      @(negedge clk);
      check("R7 reset clear", {cout_r, sum_r}, '0);
      @(negedge clk);
      check("R7 reset clear", {cout_r, sum_r}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      apply(8'h00, 8'h00, 1'b1, "R5 cin only");
      apply(8'h01, 8'h00, 1'b1, "R5 bit0 carry");
      apply(8'h55, 8'h55, 1'b0, "R2 even carries");
      apply(8'h55, 8'h55, 1'b1, "R2 even carries cin");
      apply(8'hAA, 8'hAA, 1'b0, "R3 odd carries");
      apply(8'hAA, 8'hAA, 1'b1, "R3 odd carries cin");
      apply(8'hFF, 8'h01, 1'b0, "R4 full run");
      apply(8'hFF, 8'h00, 1'b1, "R4 full run cin");
      apply(8'h7F, 8'h7F, 1'b1, "R4 no top bit");
      apply(8'hFF, 8'hFF, 1'b1, "R1 max");
      for (int k = 0; k < 400; k++) begin
         apply(8'($urandom), 8'($urandom), 1'($urandom), "R1 random");
      end
      for (int ci = 0; ci < 2; ci++) begin
         for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
               apply(8'(x), 8'(y), 1'(ci), "R1 exhaustive");
            end
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   task automatic process_seed();
      int unsigned s;
      s = $urandom(32'h1F2E3D4C);
      if (s == 0) s = 1;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule